// File: doc/BRIEF.md
# Command and Receive Unit Opcode Decoder with Counter Dump

This block sits behind a command register. When a command byte is written, it decodes the byte into one command-unit operation and one receive-unit operation. Operations that need an address take it from a general 32-bit pointer input, sampled in the same cycle as the command. The block keeps the latched base and offset addresses and the unit states on its outputs, where the fetch and transfer logic around it can use them.

The block also holds four event counters: good frames sent, good frames received, frames lost for want of a buffer, and runt frames. A dump command snapshots the counters and writes them one at a time through a 32-bit memory-write port, each write waiting for an acknowledge. The dump ends with a completion code written just past the end of the statistics area. The code tells a plain dump apart from a dump that also cleared the counters. While a dump is in flight the block reports busy, and any command offered in that time is dropped.

Top module: `cu_stat_ctrl`

## Requirements
- R1: After reset, `cu_active`, `ru_ready`, `busy`, `wr_req` and `cmd_err` are 0, and every latched address and every counter is 0.
- R2: The command byte carries the command-unit opcode in bits 7:4 and the receive-unit opcode in bits 3:0. A command-unit opcode of 1 (start) sets `cu_active` on the next cycle and loads `cu_offset` from `ptr`. `cu_active` then stays set until reset.
- R3: Command-unit opcode 6 loads `cu_base` from `ptr`. Opcode 4 loads `stats_addr` from `ptr`. Opcode 0 does nothing.
- R4: Receive-unit opcode 1 sets `ru_ready` and loads `ru_offset` from `ptr`. Receive-unit opcode 6 loads `ru_base` from `ptr`. Opcode 0 does nothing. Both fields of one command act in the same cycle.
- R5: A command whose command-unit opcode is not one of 0, 1, 4, 5, 6 or 7, or whose receive-unit opcode is not one of 0, 1 or 6, changes no state. It sets `cmd_err`, which stays set until reset.
- R6: Command-unit opcode 5 or 7 starts a dump of four 32-bit writes, in this order:

  | Order | Address | Counter |
  |-------|---------|---------|
  | 1 | `stats_addr+0` | sent-good |
  | 2 | `stats_addr+36` | received-good |
  | 3 | `stats_addr+48` | no-buffer |
  | 4 | `stats_addr+60` | runt |

  Each counter is zero-extended. Each value is little-endian: `wr_data[7:0]` belongs at byte `wr_addr`. The dumped values are the counters as they stood before the command cycle.
- R7: While `wr_req` is high and `wr_ack` is low, `wr_addr` and `wr_data` hold steady. A write completes on a cycle with both high, and the next write is presented on the following cycle.
- R8: After the four counter writes, a plain dump (opcode 5) writes 0x0000A005 to `stats_addr+STATS_BYTES`. The counters keep counting.
- R9: A dump-and-clear (opcode 7) writes 0x0000A007 as its completion code. The counters restart from zero in the command cycle, so an event in that same cycle is the first one counted afresh.
- R10: `busy` and `wr_req` are high from the cycle after a dump command until the cycle after the completion code is acknowledged. A command offered while `busy` is high is dropped: it changes no state and does not set `cmd_err`.
- R11: Each event input high in a cycle adds one to its counter. A counter wraps at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte written this cycle |
| cmd | input | 8 | Command byte: unit opcodes in 7:4 and 3:0 |
| ptr | input | ADDR_W | General pointer register value |
| ev_tx_ok | input | 1 | Good frame sent |
| ev_rx_ok | input | 1 | Good frame received |
| ev_rx_nobuf | input | 1 | Frame lost for want of a buffer |
| ev_rx_runt | input | 1 | Runt frame received |
| wr_ack | input | 1 | Memory write accepted |
| wr_req | output | 1 | Memory write pending |
| wr_addr | output | ADDR_W | Byte address of the pending write |
| wr_data | output | 32 | Little-endian data of the pending write |
| cu_active | output | 1 | Command unit started |
| ru_ready | output | 1 | Receive unit started |
| cu_base | output | ADDR_W | Latched command-unit base |
| cu_offset | output | ADDR_W | Latched command-unit offset |
| ru_base | output | ADDR_W | Latched receive-unit base |
| ru_offset | output | ADDR_W | Latched receive-unit offset |
| stats_addr | output | ADDR_W | Latched statistics area address |
| busy | output | 1 | Dump in progress |
| cmd_err | output | 1 | Sticky undefined-opcode flag |

## Verification
The assertions assume that `wr_ack` has meaning only while `wr_req` is high. They also assume that `ptr` and `cmd` are sampled only on cycles with `cmd_valid` set, and that the write target never stalls forever. The stimulus drives every input on the falling edge. It draws the acknowledge either as always-high or as a sparse pseudo-random pulse, so that writes stall for several cycles. It deliberately offers commands, including undefined ones, while a dump is running, which exercises the busy-drop rule. The bench builds the block with 4-bit counters, so that wrap-around happens within a short burst of events.

// File: rtl/cu_stat_ctrl.sv
module cu_stat_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int STATS_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              ev_tx_ok,
  input  logic              ev_rx_ok,
  input  logic              ev_rx_nobuf,
  input  logic              ev_rx_runt,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              cu_active,
  output logic              ru_ready,
  output logic [ADDR_W-1:0] cu_base,
  output logic [ADDR_W-1:0] cu_offset,
  output logic [ADDR_W-1:0] ru_base,
  output logic [ADDR_W-1:0] ru_offset,
  output logic [ADDR_W-1:0] stats_addr,
  output logic              busy,
  output logic              cmd_err
);

  localparam logic [3:0] CU_NOP      = 4'h0;
  localparam logic [3:0] CU_START    = 4'h1;
  localparam logic [3:0] CU_LD_STAT  = 4'h4;
  localparam logic [3:0] CU_DUMP     = 4'h5;
  localparam logic [3:0] CU_LD_BASE  = 4'h6;
  localparam logic [3:0] CU_DUMP_CLR = 4'h7;
  localparam logic [3:0] RU_NOP      = 4'h0;
  localparam logic [3:0] RU_START    = 4'h1;
  localparam logic [3:0] RU_LD_BASE  = 4'h6;

  localparam logic [31:0] DONE_PLAIN = 32'h0000_A005;
  localparam logic [31:0] DONE_CLEAR = 32'h0000_A007;

  localparam logic [ADDR_W-1:0] OFF_TX   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_RX   = ADDR_W'(36);
  localparam logic [ADDR_W-1:0] OFF_BUF  = ADDR_W'(48);
  localparam logic [ADDR_W-1:0] OFF_RUNT = ADDR_W'(60);
  localparam logic [ADDR_W-1:0] OFF_DONE = ADDR_W'(STATS_BYTES);
  localparam int NCNT = 4;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_RX, S_BUF, S_RUNT, S_DONE} step_t;

  step_t step;
  logic  done_clr;

  logic [3:0] cu_op, ru_op;
  logic       cu_known, ru_known;
  logic       take, exec, bad, dump_go, clr_go, beat;
  logic [NCNT-1:0] ev;
  logic [CNT_W-1:0] cnt  [NCNT];
  logic [CNT_W-1:0] snap [NCNT];
  logic [ADDR_W-1:0] off;

  assign cu_op = cmd[7:4];
  assign ru_op = cmd[3:0];
  assign ev    = {ev_rx_runt, ev_rx_nobuf, ev_rx_ok, ev_tx_ok};

  always_comb begin
    case (cu_op)
      CU_NOP, CU_START, CU_LD_STAT, CU_DUMP, CU_LD_BASE, CU_DUMP_CLR: cu_known = 1'b1;
      default: cu_known = 1'b0;
    endcase
    case (ru_op)
      RU_NOP, RU_START, RU_LD_BASE: ru_known = 1'b1;
      default: ru_known = 1'b0;
    endcase
  end

  assign take    = cmd_valid & ~busy;
  assign exec    = take & cu_known & ru_known;
  assign bad     = take & ~(cu_known & ru_known);
  assign dump_go = exec & ((cu_op == CU_DUMP) | (cu_op == CU_DUMP_CLR));
  assign clr_go  = exec & (cu_op == CU_DUMP_CLR);
  assign beat    = wr_req & wr_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cu_active  <= 1'b0;
      ru_ready   <= 1'b0;
      cu_base    <= '0;
      cu_offset  <= '0;
      ru_base    <= '0;
      ru_offset  <= '0;
      stats_addr <= '0;
      cmd_err    <= 1'b0;
    end else begin
      if (bad) cmd_err <= 1'b1;
      if (exec) begin
        case (cu_op)
          CU_START: begin
            cu_active <= 1'b1;
            cu_offset <= ptr;
          end
          CU_LD_STAT: stats_addr <= ptr;
          CU_LD_BASE: cu_base    <= ptr;
          default: ;
        endcase
        case (ru_op)
          RU_START: begin
            ru_ready  <= 1'b1;
            ru_offset <= ptr;
          end
          RU_LD_BASE: ru_base <= ptr;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[g]  <= '0;
        snap[g] <= '0;
      end else begin
        cnt[g] <= (clr_go ? '0 : cnt[g]) + CNT_W'(ev[g]);
        if (dump_go) snap[g] <= cnt[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= S_IDLE;
      done_clr <= 1'b0;
    end else if (dump_go) begin
      step     <= S_TX;
      done_clr <= clr_go;
    end else if (beat) begin
      case (step)
        S_TX:    step <= S_RX;
        S_RX:    step <= S_BUF;
        S_BUF:   step <= S_RUNT;
        S_RUNT:  step <= S_DONE;
        default: step <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    off     = OFF_TX;
    wr_data = '0;
    case (step)
      S_TX:    begin off = OFF_TX;   wr_data = 32'(snap[0]); end
      S_RX:    begin off = OFF_RX;   wr_data = 32'(snap[1]); end
      S_BUF:   begin off = OFF_BUF;  wr_data = 32'(snap[2]); end
      S_RUNT:  begin off = OFF_RUNT; wr_data = 32'(snap[3]); end
      S_DONE:  begin off = OFF_DONE; wr_data = done_clr ? DONE_CLEAR : DONE_PLAIN; end
      default: ;
    endcase
  end

  assign wr_addr = stats_addr + off;
  assign wr_req  = (step != S_IDLE);
  assign busy    = wr_req;

endmodule

// File: rtl/cu_stat_ctrl_chk.sv
module cu_stat_ctrl_chk #(
  parameter int ADDR_W      = 32,
  parameter int STATS_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd,
  input logic [ADDR_W-1:0] ptr,
  input logic              wr_ack,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              cu_active,
  input logic              ru_ready,
  input logic [ADDR_W-1:0] cu_base,
  input logic [ADDR_W-1:0] cu_offset,
  input logic [ADDR_W-1:0] ru_base,
  input logic [ADDR_W-1:0] ru_offset,
  input logic [ADDR_W-1:0] stats_addr,
  input logic              busy,
  input logic              cmd_err
);

  logic legal;
  assign legal = (cmd[7:4] inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h6, 4'h7}) &&
                 (cmd[3:0] inside {4'h0, 4'h1, 4'h6});

  assert_cu_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd == 8'h10 |=> cu_active && cu_offset == $past(ptr));

  assert_cu_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cu_active |=> cu_active);

  assert_stat_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd == 8'h40 |=> stats_addr == $past(ptr));

  assert_ru_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd == 8'h01 |=> ru_ready && ru_offset == $past(ptr));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  assert_bad_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && !legal |=> cmd_err && $stable(cu_base) && $stable(cu_offset)
      && $stable(ru_base) && $stable(ru_offset) && $stable(stats_addr)
      && $stable(cu_active) && $stable(ru_ready) && !wr_req);

  assert_dump_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd == 8'h50 |=> wr_req && wr_addr == stats_addr);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  assert_done_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_addr == stats_addr + ADDR_W'(STATS_BYTES) |->
      (wr_data == 32'h0000_A005 || wr_data == 32'h0000_A007));

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> $stable(cu_base) && $stable(cu_offset) && $stable(ru_base)
      && $stable(ru_offset) && $stable(stats_addr) && $stable(cmd_err));

endmodule

bind cu_stat_ctrl cu_stat_ctrl_chk #(.ADDR_W(ADDR_W), .STATS_BYTES(STATS_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .ptr(ptr),
  .wr_ack(wr_ack), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
  .cu_active(cu_active), .ru_ready(ru_ready), .cu_base(cu_base),
  .cu_offset(cu_offset), .ru_base(ru_base), .ru_offset(ru_offset),
  .stats_addr(stats_addr), .busy(busy), .cmd_err(cmd_err)
);

// File: tb/cu_stat_ctrl_bench.sv
module cu_stat_ctrl_bench;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int SB = 64;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmd_valid, wr_ack;
  logic [7:0] cmd;
  logic [AW-1:0] ptr;
  logic ev_tx_ok, ev_rx_ok, ev_rx_nobuf, ev_rx_runt;
  logic wr_req, cu_active, ru_ready, busy, cmd_err;
  logic [AW-1:0] wr_addr, cu_base, cu_offset, ru_base, ru_offset, stats_addr;
  logic [31:0] wr_data;

  cu_stat_ctrl #(.ADDR_W(AW), .CNT_W(CW), .STATS_BYTES(SB)) u_cu_stat_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .ptr(ptr),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok), .ev_rx_nobuf(ev_rx_nobuf),
    .ev_rx_runt(ev_rx_runt), .wr_ack(wr_ack), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .cu_active(cu_active), .ru_ready(ru_ready),
    .cu_base(cu_base), .cu_offset(cu_offset), .ru_base(ru_base),
    .ru_offset(ru_offset), .stats_addr(stats_addr), .busy(busy), .cmd_err(cmd_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit ev_on = 0;
  bit ack_slow = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  typedef struct { logic [31:0] a; logic [31:0] d; int kind; } exp_wr_t;
  exp_wr_t q[$];
  logic m_active, m_ready, m_err;
  logic [31:0] m_cbase, m_coff, m_rbase, m_roff, m_saddr;
  int m_cnt[4];

  always @(negedge clk) begin
    wr_ack      = ack_slow ? ($urandom_range(0, 3) == 0) : 1'b1;
    ev_tx_ok    = ev_on && $urandom_range(0, 1) == 1;
    ev_rx_ok    = ev_on && $urandom_range(0, 1) == 1;
    ev_rx_nobuf = ev_on && $urandom_range(0, 2) == 0;
    ev_rx_runt  = ev_on && $urandom_range(0, 3) == 0;
  end

  always @(posedge clk) begin
    logic [3:0] cu, ru;
    logic ok, clr, was_busy;
    int evs[4];
    evs = '{int'(ev_tx_ok), int'(ev_rx_ok), int'(ev_rx_nobuf), int'(ev_rx_runt)};
    clr = 1'b0;
    if (!rst_n) begin
      m_active = 0; m_ready = 0; m_err = 0;
      m_cbase = 0; m_coff = 0; m_rbase = 0; m_roff = 0; m_saddr = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
      q.delete();
    end else begin
      was_busy = (q.size() != 0);
      if (was_busy && wr_ack) void'(q.pop_front());
      if (cmd_valid && !was_busy) begin
        cu = cmd[7:4];
        ru = cmd[3:0];
        ok = (cu inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h6, 4'h7}) && (ru inside {4'h0, 4'h1, 4'h6});
        if (!ok) m_err = 1;
        else begin
          if (cu == 4'h1) begin m_active = 1; m_coff = ptr; end
          if (cu == 4'h4) m_saddr = ptr;
          if (cu == 4'h6) m_cbase = ptr;
          if (ru == 4'h1) begin m_ready = 1; m_roff = ptr; end
          if (ru == 4'h6) m_rbase = ptr;
          if (cu == 4'h5 || cu == 4'h7) begin
            q.push_back('{m_saddr + 0,  m_cnt[0], 0});
            q.push_back('{m_saddr + 36, m_cnt[1], 0});
            q.push_back('{m_saddr + 48, m_cnt[2], 0});
            q.push_back('{m_saddr + 60, m_cnt[3], 0});
            q.push_back('{m_saddr + SB, (cu == 4'h7) ? 32'h0000_A007 : 32'h0000_A005,
                          (cu == 4'h7) ? 2 : 1});
            clr = (cu == 4'h7);
          end
        end
      end
      for (int i = 0; i < 4; i++) m_cnt[i] = ((clr ? 0 : m_cnt[i]) + evs[i]) & MASK;
    end
    #2;
    if (rst_n && !done) begin
      chk("R2 cu_active", cu_active, m_active);
      chk("R2 cu_offset", cu_offset, m_coff);
      chk("R3 cu_base", cu_base, m_cbase);
      chk("R3 stats_addr", stats_addr, m_saddr);
      chk("R4 ru_ready", ru_ready, m_ready);
      chk("R4 ru_offset", ru_offset, m_roff);
      chk("R4 ru_base", ru_base, m_rbase);
      chk("R5 cmd_err", cmd_err, m_err);
      chk("R10 busy", busy, q.size() != 0);
      chk("R10 wr_req", wr_req, q.size() != 0);
      if (q.size() != 0) begin
        if (q[0].kind == 0) begin
          chk("R6 R7 write address", wr_addr, q[0].a);
          chk("R6 R11 counter value", wr_data, q[0].d);
        end else if (q[0].kind == 1) begin
          chk("R8 plain completion address", wr_addr, q[0].a);
          chk("R8 plain completion code", wr_data, q[0].d);
        end else begin
          chk("R9 clear completion address", wr_addr, q[0].a);
          chk("R9 clear completion code", wr_data, q[0].d);
        end
      end
    end
  end

  task automatic issue(input logic [7:0] c, input logic [31:0] p);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; ptr = p;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 8'h00; ptr = 32'hFFFF_FFFF;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd = 8'h00; ptr = '0;
    repeat (3) @(negedge clk);
    chk("R1 cu_active", cu_active, 0);
    chk("R1 ru_ready", ru_ready, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wr_req", wr_req, 0);
    chk("R1 cmd_err", cmd_err, 0);
    chk("R1 stats_addr", stats_addr, 0);
    chk("R1 cu_base", cu_base, 0);
    chk("R1 ru_offset", ru_offset, 0);
    rst_n = 1'b1;

    issue(8'h50, 32'h0);
    wait_idle();
    issue(8'h10, 32'h0000_2000);
    issue(8'h60, 32'h1111_0000);
    issue(8'h40, 32'h0000_8000);
    issue(8'h01, 32'h0000_3000);
    issue(8'h06, 32'h2222_0000);
    issue(8'h61, 32'h4444_0040);
    issue(8'h00, 32'h5555_0000);

    ev_on = 1;
    repeat (40) @(negedge clk);
    issue(8'h50, 32'h0);
    issue(8'h60, 32'hDEAD_0000);
    issue(8'hF0, 32'h0);
    wait_idle();

    ack_slow = 1;
    issue(8'h70, 32'h0);
    issue(8'h40, 32'hBEEF_0000);
    wait_idle();
    repeat (25) @(negedge clk);
    issue(8'h50, 32'h0);
    wait_idle();

    ev_on = 0;
    issue(8'h20, 32'h9999_0000);
    issue(8'h03, 32'h9999_0004);
    issue(8'h12, 32'h9999_0008);
    issue(8'h70, 32'h0);
    wait_idle();
    issue(8'h40, 32'h0000_C000);
    issue(8'h50, 32'h0);
    wait_idle();
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule